// File: doc/BRIEF.md
# Ternary Polynomial Multiplier Modulo 3

This block multiplies two polynomials whose coefficients are ternary, meaning each one is 0, +1 or −1 modulo 3. It first forms the cyclic product modulo x^n − 1 and then reduces that product by the all-ones cyclotomic polynomial of degree n − 1, where n is prime. It builds no integer multiplier and no integer adder. Each coefficient product comes from zeroising and swapping bits, and each coefficient sum comes from a 2-bit add that wraps. Because of this it can run beside a wide-integer ring multiplier without taking any of that multiplier's arithmetic.

Operands and results cross a shared 64-bit bus, 32 coefficients to a word, through a request/grant handshake. The block therefore fits into whatever bus slots the neighbouring engine leaves free. Output words leave in ascending coefficient order. A following engine can therefore begin consuming the lower half of the result before the upper half has been written. A start pulse latches the ring size n for the whole operation, and a done pulse closes it.

Top module: `trit_poly_mul`

## Requirements
- R1: Each coefficient is 2 bits wide. Code 0 means 0, code 1 means +1 and code 2 means −1. An input coefficient with code 3 is treated as 0, and no stored or output coefficient ever holds code 3.
- R2: A bus word carries 32 coefficients, and coefficient k sits in word k/32 at bits 2(k%32)+1 down to 2(k%32). Input lanes at index n or above are ignored, and output lanes at index n or above are zero.
- R3: The result is r_k = (c_k − c_(n−1)) mod 3 for k < n−1, with r_(n−1) = 0. Here c is the cyclic product a·b mod (x^n − 1, 3), and n is any value from 2 to N_MAX latched at start.
- R4: After start the block raises a read request (bus_req_o high, bus_we_o low). It takes W = ceil(n/32) words of operand a and then W words of operand b, one word on each clock edge where request and grant are both high. The request stays high until it is granted.
- R5: After the edge that accepts the last operand word, the block makes no bus request for n+1 cycles: n multiply-accumulate steps and one reduction step. It then raises the write request.
- R6: The block writes W result words in ascending word order, with bus_we_o and bus_req_o high. done_o is a one-cycle pulse in the cycle after the final write handshake.
- R7: A start pulse while an operation is in progress is ignored. The running operation keeps its n and its result.
- R8: During and after reset, bus_req_o, bus_we_o and done_o are low and bus_wdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| n_i | input | $clog2(N_MAX+1) | Ring size n, latched at start |
| done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | High for a write request, low for a read request |
| bus_gnt_i | input | 1 | Bus grant; a transfer happens on an edge where request and grant are both high |
| bus_rdata_i | input | BUS_W | Operand word, sampled on a read handshake |
| bus_wdata_o | output | BUS_W | Result word, valid while a write request is high |

## Verification
An operand word is consumed on the edge of its handshake. The first write request must appear exactly n+2 falling edges after the falling edge at which the bench grants the last read word, and done_o must appear on the falling edge right after the one at which the last write is granted. The bench drives grant and read data on the falling edge. It samples the request, write data and done on the falling edge too, so every value it compares was settled by the preceding rising edge. It counts falling edges to check both latency windows exactly, including runs where grants are withheld on some cycles. Expected words come from a direct mod-3 convolution followed by the top-coefficient subtraction. This reference is compared for every product at n = 2 and n = 3, and for patterned and pseudo-random operands at prime n up to 61.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  typedef logic [1:0] trit_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MAC,
    ST_RED,
    ST_STORE
  } tmul_state_e;

  // -x mod 3: swap the two bits (1 <-> 2, 0 stays 0)
  function automatic trit_t trit_neg(trit_t x);
    return {x[0], x[1]};
  endfunction

  // 2-bit add with wrap: 3 -> 0, 4 -> 1
  function automatic trit_t trit_add(trit_t x, trit_t y);
    logic [2:0] s;
    logic [2:0] w;
    s = {1'b0, x} + {1'b0, y};
    w = s - 3'd3;
    return (s >= 3'd3) ? w[1:0] : s[1:0];
  endfunction

  function automatic trit_t trit_mul(trit_t x, trit_t y);
    if (x == 2'd0 || y == 2'd0) return 2'd0;
    return (x == 2'd2) ? trit_neg(y) : y;
  endfunction

  function automatic trit_t trit_clean(trit_t x);
    return (x == 2'd3) ? 2'd0 : x;
  endfunction

endpackage

// File: rtl/tmul_cell.sv
module tmul_cell
  import tmul_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  mac_i,
  input  logic  red_i,
  input  logic  top_i,
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t sub_i,
  output trit_t c_o
);

  trit_t c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 2'd0;
    end else if (clr_i) begin
      c_q <= 2'd0;
    end else if (mac_i) begin
      c_q <= trit_add(c_q, trit_mul(a_i, b_i));
    end else if (red_i) begin
      c_q <= top_i ? 2'd0 : trit_add(c_q, trit_neg(sub_i));
    end
  end

  assign c_o = c_q;

  assert_acc_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_q != 2'd3);

endmodule

// File: rtl/tmul_ctrl.sv
module tmul_ctrl
  import tmul_pkg::*;
#(
  parameter int N_MAX = 64,
  parameter int CPW   = 32,
  localparam int NW   = $clog2(N_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] n_i,
  input  logic          bus_gnt_i,
  output tmul_state_e   state_o,
  output logic [NW-1:0] cnt_o,
  output logic [NW-1:0] n_o,
  output logic [NW-1:0] words_o,
  output logic          clr_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          done_o
);

  tmul_state_e   state_q;
  logic [NW-1:0] cnt_q, n_q, words_q, words_n, last_rd, last_wr, last_mac;
  logic          done_q;

  assign words_n  = NW'((int'(n_i) + CPW - 1) / CPW);
  assign last_rd  = NW'({words_q, 1'b0} - 1'b1);
  assign last_wr  = words_q - 1'b1;
  assign last_mac = n_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      n_q     <= '0;
      words_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          cnt_q   <= '0;
          n_q     <= n_i;
          words_q <= words_n;
        end
        ST_LOAD: if (bus_gnt_i) begin
          if (cnt_q == last_rd) begin
            state_q <= ST_MAC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MAC: begin
          if (cnt_q == last_mac) begin
            state_q <= ST_RED;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RED: begin
          state_q <= ST_STORE;
          cnt_q   <= '0;
        end
        ST_STORE: if (bus_gnt_i) begin
          if (cnt_q == last_wr) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign n_o       = n_q;
  assign words_o   = words_q;
  assign clr_o     = (state_q == ST_IDLE) && start_i;
  assign bus_req_o = (state_q == ST_LOAD) || (state_q == ST_STORE);
  assign bus_we_o  = (state_q == ST_STORE);
  assign done_o    = done_q;

  assert_req_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && ($stable(bus_we_o))));

  assert_we_has_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> bus_req_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_n_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(n_q));

endmodule

// File: rtl/trit_poly_mul.sv
module trit_poly_mul
  import tmul_pkg::*;
#(
  parameter int N_MAX = 64,
  parameter int BUS_W = 64,
  localparam int NW   = $clog2(N_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NW-1:0]    n_i,
  output logic             done_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  input  logic             bus_gnt_i,
  input  logic [BUS_W-1:0] bus_rdata_i,
  output logic [BUS_W-1:0] bus_wdata_o
);

  localparam int CPW  = BUS_W / 2;
  localparam int WMAX = (N_MAX + CPW - 1) / CPW;

  tmul_state_e   state_w;
  logic [NW-1:0] cnt_w, n_q, words_q;
  logic          clr, ld_hs, mac_en, red_en;

  trit_t a_q [N_MAX];
  trit_t b_q [N_MAX];
  trit_t c_w [N_MAX];
  trit_t b_last, c_last;
  logic [WMAX*BUS_W-1:0] c_flat;

  tmul_ctrl #(.N_MAX(N_MAX), .CPW(CPW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .n_i       (n_i),
    .bus_gnt_i (bus_gnt_i),
    .state_o   (state_w),
    .cnt_o     (cnt_w),
    .n_o       (n_q),
    .words_o   (words_q),
    .clr_o     (clr),
    .bus_req_o (bus_req_o),
    .bus_we_o  (bus_we_o),
    .done_o    (done_o)
  );

  assign ld_hs  = (state_w == ST_LOAD) && bus_gnt_i;
  assign mac_en = (state_w == ST_MAC);
  assign red_en = (state_w == ST_RED);

  // coefficient n-1 of the rotating operand and of the accumulator
  always_comb begin
    b_last = 2'd0;
    c_last = 2'd0;
    for (int k = 0; k < N_MAX; k++) begin
      if (k == int'(n_q) - 1) begin
        b_last = b_q[k];
        c_last = c_w[k];
      end
    end
  end

  // operand a shifts down one step per cycle, operand b rotates within n lanes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_MAX; k++) begin
        a_q[k] <= 2'd0;
        b_q[k] <= 2'd0;
      end
    end else if (clr) begin
      for (int k = 0; k < N_MAX; k++) begin
        a_q[k] <= 2'd0;
        b_q[k] <= 2'd0;
      end
    end else if (ld_hs) begin
      for (int k = 0; k < N_MAX; k++) begin
        if (int'(cnt_w) == k / CPW)
          a_q[k] <= (k < int'(n_q)) ? trit_clean(bus_rdata_i[2*(k%CPW) +: 2]) : 2'd0;
        else if (int'(cnt_w) == int'(words_q) + k / CPW)
          b_q[k] <= (k < int'(n_q)) ? trit_clean(bus_rdata_i[2*(k%CPW) +: 2]) : 2'd0;
      end
    end else if (mac_en) begin
      for (int k = 0; k < N_MAX - 1; k++) a_q[k] <= a_q[k+1];
      a_q[N_MAX-1] <= 2'd0;
      b_q[0] <= b_last;
      for (int k = 1; k < N_MAX; k++) b_q[k] <= (k < int'(n_q)) ? b_q[k-1] : 2'd0;
    end
  end

  for (genvar k = 0; k < N_MAX; k++) begin : g_cell
    tmul_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .mac_i  (mac_en && (k < int'(n_q))),
      .red_i  (red_en && (k < int'(n_q))),
      .top_i  (k == int'(n_q) - 1),
      .a_i    (a_q[0]),
      .b_i    (b_q[k]),
      .sub_i  (c_last),
      .c_o    (c_w[k])
    );
  end

  always_comb begin
    c_flat = '0;
    for (int k = 0; k < N_MAX; k++) c_flat[2*k +: 2] = c_w[k];
  end

  always_comb begin
    bus_wdata_o = '0;
    if (state_w == ST_STORE) begin
      for (int w = 0; w < WMAX; w++) begin
        if (int'(cnt_w) == w) bus_wdata_o = c_flat[w*BUS_W +: BUS_W];
      end
    end
  end

  assert_operand_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_q[0] != 2'd3) && (b_last != 2'd3));

  assert_top_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_STORE) |-> (c_last == 2'd0));

  assert_quiet_compute_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en || red_en) |-> !bus_req_o);

endmodule

// File: tb/sim_trit_poly_mul.sv
module sim_trit_poly_mul;

  localparam int N_MAX = 64;
  localparam int BUS_W = 64;
  localparam int NW    = $clog2(N_MAX + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [NW-1:0]    n_i = '0;
  logic             bus_gnt_i = 1'b0;
  logic [BUS_W-1:0] bus_rdata_i = '0;
  logic             done_o, bus_req_o, bus_we_o;
  logic [BUS_W-1:0] bus_wdata_o;

  trit_poly_mul #(.N_MAX(N_MAX), .BUS_W(BUS_W)) u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .n_i         (n_i),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_wdata_o (bus_wdata_o)
  );

  always #4 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [31:0] seed = 32'h1d87_4e3b;

  int ta [N_MAX];
  int tb [N_MAX];
  logic [BUS_W-1:0] in_w  [4];
  logic [BUS_W-1:0] exp_w [2];
  logic [BUS_W-1:0] mask_w[2];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int rnd(int m);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed % 32'(m));
  endfunction

  function automatic int tval(int x);
    return (x == 1) ? 1 : ((x == 2) ? -1 : 0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic build(input int n);
    int c [N_MAX];
    int w;
    w = (n + 31) / 32;
    for (int k = 0; k < n; k++) begin
      int s;
      s = 0;
      for (int i = 0; i < n; i++) s += tval(ta[i]) * tval(tb[(k - i + n) % n]);
      c[k] = ((s % 3) + 3) % 3;
    end
    for (int x = 0; x < 2; x++) begin
      exp_w[x]  = '0;
      mask_w[x] = '0;
    end
    for (int k = 0; k < n; k++) begin
      int r;
      r = (k == n - 1) ? 0 : (((c[k] - c[n-1]) % 3) + 3) % 3;
      exp_w[k/32][2*(k%32) +: 2] = 2'(r);
      mask_w[k/32][2*(k%32) +: 2] = 2'b11;
    end
    for (int x = 0; x < 2 * w; x++) begin
      for (int j = 0; j < 32; j++) begin
        int idx;
        idx = (x % w) * 32 + j;
        if (idx < n) in_w[x][2*j +: 2] = 2'((x < w) ? ta[idx] : tb[idx]);
        else         in_w[x][2*j +: 2] = 2'(rnd(4));
      end
    end
  endtask

  task automatic run_op(input int n, input bit stall, input bit busy_start, input string tag);
    int w, rd, wr, neg, last_rd, last_wr, first_wr;
    bit fin, inj, g;
    w = (n + 31) / 32;
    build(n);
    rd = 0; wr = 0; neg = 0; last_rd = -1; last_wr = -1; first_wr = -1;
    fin = 0; inj = 0;
    n_i = NW'(n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!fin) begin
      neg++;
      start_i = 1'b0;
      bus_gnt_i = 1'b0;
      if (done_o) begin
        fin = 1;
        check(neg == last_wr + 1 && wr == w, "R6 done one cycle after last write",
              64'(neg - last_wr), 64'd1);
        check(rd == 2 * w, "R4 operand word count", 64'(rd), 64'(2 * w));
      end else if (neg > 3000) begin
        fin = 1;
        check(1'b0, "R4 operation hung", 64'(neg), 64'd0);
      end else if (bus_req_o && !bus_we_o) begin
        g = stall ? (neg % 3 != 1) : 1'b1;
        bus_rdata_i = (rd < 4) ? in_w[rd] : '0;
        bus_gnt_i = g;
        if (g) begin
          rd++;
          if (rd == 2 * w) last_rd = neg;
        end
      end else if (bus_req_o && bus_we_o) begin
        if (first_wr < 0) begin
          first_wr = neg;
          check(first_wr - last_rd == n + 2, "R5 compute latency",
                64'(first_wr - last_rd), 64'(n + 2));
        end
        g = stall ? (neg % 3 != 2) : 1'b1;
        bus_gnt_i = g;
        if (g) begin
          if (wr < 2) begin
            check((bus_wdata_o & ~mask_w[wr]) == '0, "R2 lanes above n zero",
                  bus_wdata_o & ~mask_w[wr], '0);
            check(bus_wdata_o == exp_w[wr], tag, bus_wdata_o, exp_w[wr]);
          end else begin
            check(1'b0, "R6 extra write word", 64'(wr), 64'(w));
          end
          wr++;
          last_wr = neg;
        end
      end
      if (busy_start && !inj && last_rd >= 0 && neg == last_rd + 3) begin
        start_i = 1'b1;
        n_i = NW'(n == 61 ? 7 : 61);
        inj = 1;
      end
      @(negedge clk_i);
    end
    bus_gnt_i = 1'b0;
    start_i = 1'b0;
  endtask

  initial begin
    int ns [11];
    ns = '{2, 3, 5, 7, 11, 13, 17, 31, 37, 59, 61};
    repeat (3) @(negedge clk_i);
    check(!bus_req_o && !bus_we_o && !done_o && bus_wdata_o == '0, "R8 reset state",
          {bus_wdata_o[60:0], bus_req_o, bus_we_o, done_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!bus_req_o && !done_o, "R8 idle after reset", {62'd0, bus_req_o, done_o}, '0);

    // exhaustive at n = 2 and n = 3 (R3)
    for (int n = 2; n <= 3; n++) begin
      int lim;
      lim = (n == 2) ? 9 : 27;
      for (int av = 0; av < lim; av++) begin
        for (int bv = 0; bv < lim; bv++) begin
          int x, y;
          x = av; y = bv;
          for (int k = 0; k < n; k++) begin
            ta[k] = x % 3; x = x / 3;
            tb[k] = y % 3; y = y / 3;
          end
          run_op(n, (av + bv) % 4 == 0, 1'b0, "R3 exhaustive product");
        end
      end
    end

    // patterned and pseudo-random operands over several prime n
    foreach (ns[i]) begin
      int n;
      n = ns[i];
      for (int kind = 0; kind < 7; kind++) begin
        for (int k = 0; k < n; k++) begin
          ta[k] = rnd(3);
          tb[k] = rnd(3);
          case (kind)
            1: ta[k] = 0;
            2: ta[k] = (k == 0) ? 1 : 0;
            3: ta[k] = (k == n - 1) ? 2 : 0;
            4: begin ta[k] = 2; tb[k] = 2; end
            5: begin
              if (rnd(3) == 0) ta[k] = 3;
              if (rnd(3) == 0) tb[k] = 3;
            end
            default: ;
          endcase
        end
        if (kind == 5)      run_op(n, 1'b0, 1'b0, "R1 code 3 read as zero");
        else if (kind == 6) run_op(n, 1'b1, n >= 5, "R7 busy start ignored");
        else                run_op(n, kind[0], 1'b0, "R3 reduced product");
        @(negedge clk_i);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule